// File: doc/BRIEF.md
# DMA Cycle I/O Address Decoder

This block sits on the expansion side of a two-cycle DMA transfer, where the host performs the memory half and the I/O half as separate bus cycles. It watches host I/O data phases and claims the few reserved addresses that carry a DMA I/O phase. It claims them only while this device holds a DMA grant. The address itself tells the block two things: whether the cycle is a normal or a verify transfer, and whether address bit 2 marks the last transfer of the buffer.

A claimed cycle turns into registered strobes toward a legacy peripheral: an acknowledge, a terminal-count flag, a read or write strobe, and a verify indication. Every strobe appears one clock after the sampled data phase and lasts one clock. Peripheral data always moves on the lowest byte lanes. Write data is masked by the byte enables. Read data is steered onto the low lanes and the unused lanes are zero.

Top module: `dma_io_decoder`

## Requirements
- R1: While `rstN` is low, every strobe output is low, `perWdata` is zero and `hostRdata` is zero.
- R2: A data phase sampled while `dmaGrant` is low is not claimed: the next clock shows `dackOut`, `tcOut`, `perRd`, `perWr` and `verifyOut` all low.
- R3: A granted write to address 0x000 or 0x004 is claimed. One clock later `dackOut` and `perWr` are high and `perRd` is low.
- R4: A granted read from address 0x000 or 0x004 is claimed. One clock later `dackOut` and `perRd` are high and `perWr` is low.
- R5: `tcOut` is high in exactly those clocks where `dackOut` is high and the claimed address had bit 2 set (0x004 or 0x0C4).
- R6: A granted read from 0x0C0 or 0x0C4 is a verify cycle. One clock later `dackOut` and `verifyOut` are high, `perRd` and `perWr` are low, and `hostRdata` is zero.
- R7: A write to 0x0C0 or 0x0C4 is not claimed and produces no strobe.
- R8: The byte enables `byteEn` are active high with bit i for byte lane i. Only 4'b0001 (byte) and 4'b0011 (word) are claimed. Any pattern with bit 2 or bit 3 set, or with bit 0 clear, produces no strobe.
- R9: Any address other than 0x000, 0x004, 0x0C0 and 0x0C4 produces no strobe, even with the grant active.
- R10: On a claimed write, `perWdata` in the strobe clock holds `hostWdata` lane 0. It holds lane 1 when `byteEn` bit 1 was set and zero otherwise.
- R11: While `perRd` is high, `hostRdata[7:0]` is `perRdata[7:0]`. `hostRdata[15:8]` is `perRdata[15:8]` for a word access and zero for a byte access. Bits 31:16 are zero. While `perRd` is low, `hostRdata` is zero.
- R12: The strobes follow each sampled clock separately. A clock with `ioValid` low is followed by a clock with every strobe low, so a one-clock data phase gives a one-clock strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dmaGrant | input | 1 | DMA grant to this device is active |
| ioValid | input | 1 | Host I/O data phase in this clock |
| ioWrite | input | 1 | 1 = I/O write, 0 = I/O read |
| ioAddr | input | 16 | Host I/O address |
| byteEn | input | 4 | Host byte enables, active high |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Read data returned to the host |
| perRdata | input | 16 | Data from the peripheral |
| perWdata | output | 16 | Data to the peripheral |
| dackOut | output | 1 | DMA acknowledge to the peripheral |
| tcOut | output | 1 | Last transfer of the buffer |
| perRd | output | 1 | Peripheral read strobe |
| perWr | output | 1 | Peripheral write strobe |
| verifyOut | output | 1 | Current acknowledge is a verify cycle |

## Verification
The assertions assume that the host presents stable address, direction, byte enables and data around each sampled edge. They also assume that `dmaGrant` is settled when a data phase is sampled, because every property is stated one clock after that sample. The bench drives all inputs on the falling edge, so each rising edge sees settled values. It checks the strobes one full clock later. The vectors combine grant, direction, address and byte-enable patterns, and apply each of them for exactly one sampled clock.

// File: rtl/dma_dec_pkg.sv
package dma_dec_pkg;

  // Registered strobe set handed from control to datapath and ports
  typedef struct packed {
    logic dack;
    logic tc;
    logic rd;
    logic wr;
    logic verify;
  } dmaStrb_t;

endpackage

// File: rtl/dma_dec_ctrl.sv
module dma_dec_ctrl
  import dma_dec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BE_W      = 4,
  parameter int PER_BE    = 2,
  parameter int TC_BIT    = 2,
  parameter int BASE_NORM = 'h000,
  parameter int BASE_VFY  = 'h0C0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaGrant,
  input  logic              ioValid,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [BE_W-1:0]   byteEn,
  output logic              capture,
  output dmaStrb_t          strbQ
);

  localparam logic [ADDR_W-1:0] TC_MASK  = ADDR_W'(1) << TC_BIT;
  localparam logic [ADDR_W-1:0] NORM_ADR = ADDR_W'(BASE_NORM);
  localparam logic [ADDR_W-1:0] VFY_ADR  = ADDR_W'(BASE_VFY);

  logic     isNorm, isVfy, beOk, claimNow;
  dmaStrb_t strbD;

  always_comb begin
    isNorm   = (ioAddr & ~TC_MASK) == NORM_ADR;
    isVfy    = (ioAddr & ~TC_MASK) == VFY_ADR;
    beOk     = byteEn[0] && (byteEn[BE_W-1:PER_BE] == '0);
    claimNow = ioValid && dmaGrant && beOk && (isNorm || (isVfy && !ioWrite));

    strbD        = '0;
    strbD.dack   = claimNow;
    strbD.tc     = claimNow && ioAddr[TC_BIT];
    strbD.rd     = claimNow && isNorm && !ioWrite;
    strbD.wr     = claimNow && isNorm && ioWrite;
    strbD.verify = claimNow && isVfy;
  end

  assign capture = claimNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strbQ <= '0;
    else       strbQ <= strbD;
  end

  // R2: no grant, no acknowledge
  p_no_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    !dmaGrant |=> !strbQ.dack);

  // R12: idle clock gives idle strobes
  p_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ioValid |=> (strbQ == '0));

  // R7: verify write never claimed
  p_vfy_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && ioWrite && isVfy) |=> !strbQ.dack);

  // R8: upper lane enables block the claim
  p_upper_lane_r8: assert property (@(posedge clk) disable iff (!rstN)
    (byteEn[BE_W-1:PER_BE] != '0) |=> !strbQ.dack);

  // R5: terminal count only alongside acknowledge
  p_tc_with_dack_r5: assert property (@(posedge clk) disable iff (!rstN)
    strbQ.tc |-> strbQ.dack);

  // R3: read and write strobes are exclusive
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strbQ.rd && strbQ.wr));

  // R6: verify moves no data
  p_vfy_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    strbQ.verify |-> (strbQ.dack && !strbQ.rd && !strbQ.wr));

endmodule

// File: rtl/dma_dec_dp.sv
module dma_dec_dp
  import dma_dec_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capture,
  input  logic [HOST_W/8-1:0] byteEn,
  input  logic [HOST_W-1:0] hostWdata,
  input  logic [PER_W-1:0]  perRdata,
  input  dmaStrb_t          strbQ,
  output logic [PER_W-1:0]  perWdata,
  output logic [HOST_W-1:0] hostRdata
);

  localparam int BE_W   = HOST_W / 8;
  localparam int PER_BE = PER_W / 8;

  logic [PER_BE-1:0] laneQ;

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    if (i < PER_BE) begin : g_low
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          laneQ[i]          <= 1'b0;
          perWdata[i*8 +: 8] <= '0;
        end else begin
          if (capture) laneQ[i] <= byteEn[i];
          perWdata[i*8 +: 8] <= (capture && byteEn[i]) ? hostWdata[i*8 +: 8] : 8'h00;
        end
      end
      assign hostRdata[i*8 +: 8] = (strbQ.rd && laneQ[i]) ? perRdata[i*8 +: 8] : 8'h00;
    end else begin : g_high
      assign hostRdata[i*8 +: 8] = 8'h00;
    end
  end

  // R10: byte write leaves the upper peripheral lane clear
  p_wdata_lane_r10: assert property (@(posedge clk) disable iff (!rstN)
    (capture && !byteEn[1]) |=> (perWdata[15:8] == 8'h00));

  // R11: no read strobe, no returned data
  p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strbQ.rd |-> (hostRdata == '0));

endmodule

// File: rtl/dma_io_decoder.sv
module dma_io_decoder
  import dma_dec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int HOST_W    = 32,
  parameter int PER_W     = 16,
  parameter int TC_BIT    = 2,
  parameter int BASE_NORM = 'h000,
  parameter int BASE_VFY  = 'h0C0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dmaGrant,
  input  logic                ioValid,
  input  logic                ioWrite,
  input  logic [ADDR_W-1:0]   ioAddr,
  input  logic [HOST_W/8-1:0] byteEn,
  input  logic [HOST_W-1:0]   hostWdata,
  output logic [HOST_W-1:0]   hostRdata,
  input  logic [PER_W-1:0]    perRdata,
  output logic [PER_W-1:0]    perWdata,
  output logic                dackOut,
  output logic                tcOut,
  output logic                perRd,
  output logic                perWr,
  output logic                verifyOut
);

  localparam int BE_W   = HOST_W / 8;
  localparam int PER_BE = PER_W / 8;

  logic     capture;
  dmaStrb_t strbQ;

  dma_dec_ctrl #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .PER_BE(PER_BE), .TC_BIT(TC_BIT),
    .BASE_NORM(BASE_NORM), .BASE_VFY(BASE_VFY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .dmaGrant(dmaGrant), .ioValid(ioValid),
    .ioWrite(ioWrite), .ioAddr(ioAddr), .byteEn(byteEn),
    .capture(capture), .strbQ(strbQ)
  );

  dma_dec_dp #(.HOST_W(HOST_W), .PER_W(PER_W)) u_dp (
    .clk(clk), .rstN(rstN), .capture(capture), .byteEn(byteEn),
    .hostWdata(hostWdata), .perRdata(perRdata), .strbQ(strbQ),
    .perWdata(perWdata), .hostRdata(hostRdata)
  );

  assign dackOut   = strbQ.dack;
  assign tcOut     = strbQ.tc;
  assign perRd     = strbQ.rd;
  assign perWr     = strbQ.wr;
  assign verifyOut = strbQ.verify;

endmodule

// File: tb/dma_io_decoder_bench.sv
module dma_io_decoder_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dmaGrant = 1'b0, ioValid = 1'b0, ioWrite = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [3:0]  byteEn = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic [15:0] perRdata = '0;
  logic [15:0] perWdata;
  logic        dackOut, tcOut, perRd, perWr, verifyOut;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_io_decoder u_dma_io_decoder (
    .clk(clk), .rstN(rstN), .dmaGrant(dmaGrant), .ioValid(ioValid),
    .ioWrite(ioWrite), .ioAddr(ioAddr), .byteEn(byteEn),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .perRdata(perRdata),
    .perWdata(perWdata), .dackOut(dackOut), .tcOut(tcOut), .perRd(perRd),
    .perWr(perWr), .verifyOut(verifyOut)
  );

  typedef struct packed {
    logic        grant;
    logic        wr;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [4:0]  expd;   // dack, tc, rd, wr, verify
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 16'h0000, 4'b0001, 5'b10010},  // R3
    '{1'b1, 1'b1, 16'h0004, 4'b0011, 5'b11010},  // R3 R5
    '{1'b1, 1'b0, 16'h0000, 4'b0011, 5'b10100},  // R4
    '{1'b1, 1'b0, 16'h0004, 4'b0001, 5'b11100},  // R4 R5
    '{1'b1, 1'b0, 16'h00C0, 4'b0001, 5'b10001},  // R6
    '{1'b1, 1'b0, 16'h00C4, 4'b0011, 5'b11001},  // R6 R5
    '{1'b1, 1'b1, 16'h00C0, 4'b0001, 5'b00000},  // R7
    '{1'b1, 1'b1, 16'h00C4, 4'b0011, 5'b00000},  // R7
    '{1'b0, 1'b1, 16'h0000, 4'b0001, 5'b00000},  // R2
    '{1'b0, 1'b0, 16'h00C4, 4'b0001, 5'b00000},  // R2
    '{1'b1, 1'b0, 16'h0000, 4'b0111, 5'b00000},  // R8
    '{1'b1, 1'b0, 16'h0004, 4'b1001, 5'b00000},  // R8
    '{1'b1, 1'b0, 16'h0000, 4'b0010, 5'b00000},  // R8
    '{1'b1, 1'b0, 16'h0008, 4'b0001, 5'b00000},  // R9
    '{1'b1, 1'b0, 16'h00C8, 4'b0001, 5'b00000},  // R9
    '{1'b1, 1'b0, 16'h0100, 4'b0001, 5'b00000},  // R9
    '{1'b1, 1'b1, 16'h01C4, 4'b0011, 5'b00000}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] strobes();
    return {dackOut, tcOut, perRd, perWr, verifyOut};
  endfunction

  // drive one data phase on the falling edge, return at the next falling edge
  task automatic phase(input logic g, input logic v, input logic w,
                       input logic [15:0] a, input logic [3:0] be);
    dmaGrant = g; ioValid = v; ioWrite = w; ioAddr = a; byteEn = be;
    @(negedge clk);
    dmaGrant = 1'b0; ioValid = 1'b0; ioWrite = 1'b0; ioAddr = '0; byteEn = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 strobes", {27'd0, strobes()}, 32'd0);
    chk("R1 perWdata", {16'd0, perWdata}, 32'd0);
    chk("R1 hostRdata", hostRdata, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // vector walk
    hostWdata = 32'hA5A5_5A5A;
    for (int i = 0; i < NV; i++) begin
      phase(VECS[i].grant, 1'b1, VECS[i].wr, VECS[i].addr, VECS[i].be);
      chk($sformatf("R2-R9 vector %0d strobes", i), {27'd0, strobes()}, {27'd0, VECS[i].expd});
    end

    // R12: idle clock with otherwise good inputs, then a single pulse
    phase(1'b1, 1'b0, 1'b1, 16'h0000, 4'b0001);
    chk("R12 idle", {27'd0, strobes()}, 32'd0);
    phase(1'b1, 1'b1, 1'b1, 16'h0000, 4'b0001);
    chk("R12 pulse", {27'd0, strobes()}, {27'd0, 5'b10010});
    @(negedge clk);
    chk("R12 pulse ends", {27'd0, strobes()}, 32'd0);

    // R10: write lane masking
    hostWdata = 32'h1234_5678;
    phase(1'b1, 1'b1, 1'b1, 16'h0000, 4'b0001);
    chk("R10 byte write", {16'd0, perWdata}, 32'h0000_0078);
    phase(1'b1, 1'b1, 1'b1, 16'h0004, 4'b0011);
    chk("R10 word write", {16'd0, perWdata}, 32'h0000_5678);

    // R11: read steering
    perRdata = 16'hBEEF;
    phase(1'b1, 1'b1, 1'b0, 16'h0000, 4'b0011);
    chk("R11 word read", hostRdata, 32'h0000_BEEF);
    phase(1'b1, 1'b1, 1'b0, 16'h0004, 4'b0001);
    chk("R11 byte read", hostRdata, 32'h0000_00EF);
    @(negedge clk);
    chk("R11 no strobe", hostRdata, 32'd0);

    // R6: verify returns no data
    phase(1'b1, 1'b1, 1'b0, 16'h00C0, 4'b0011);
    chk("R6 verify data", hostRdata, 32'd0);

    // R5: terminal count gone on the next normal transfer
    phase(1'b1, 1'b1, 1'b0, 16'h0004, 4'b0011);
    chk("R5 tc set", {31'd0, tcOut}, 32'd1);
    phase(1'b1, 1'b1, 1'b0, 16'h0000, 4'b0011);
    chk("R5 tc clear", {31'd0, tcOut}, 32'd0);

    // R1: reset mid-transfer clears outputs
    dmaGrant = 1'b1; ioValid = 1'b1; ioWrite = 1'b1; byteEn = 4'b0011;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R1 async reset", {27'd0, strobes()}, 32'd0);
    chk("R1 async reset data", {16'd0, perWdata}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule